// File: doc/BRIEF.md
# Expansion DMA Register Interface

This block is the register file that a host CPU sees when it programs a RAM-expansion DMA controller over an 8-bit I/O bus. It decodes a 32-byte window. The first eleven offsets hold the controller's registers: status, command, a 16-bit host address, a 16-bit expansion address, an expansion bank, a 16-bit transfer length, an interrupt mask and an address-control byte. The remaining offsets read as all ones. Bus reads are combinational. Writes, and the side effects of reads, take effect on the rising clock edge.

The block hands the programmed values to a separate transfer engine. It raises a one-cycle start pulse, either at once or when an external trigger strobe arrives. It takes back completion and verify-mismatch events, and the engine's updated address and length values. From these it keeps the status flags and the interrupt request. Every multi-byte register has a shadow copy. A byte write merges with the other half of the shadow. When auto-reload is selected, a completed transfer restores the live registers from the shadows.

Top module: `xdma_regs`

## Requirements
- R1: After reset the registers read as follows: offset 0x00 = {4'b0001, VERSION} with the default BIG_MEM = 1, 0x01 = 0x10, 0x02..0x05 = 0x00, 0x06 = 0xF8, 0x07 = 0xFF, 0x08 = 0xFF, 0x09 = 0x1F, 0x0A = 0x3F, and irq is low.
- R2: Offsets 0x0B..0x1F always read 0xFF, and writes to them change no register and do not change irq.
- R3: Status (offset 0x00) has the following layout: bits 3:0 hold VERSION, bit 4 is BIG_MEM, bit 5 is verify error, bit 6 is end of block and bit 7 is interrupt pending. irq equals bit 7. Writes to status are ignored.
- R4: A status read returns the current value. On that clock edge it clears bits 7:5 and drops irq. An engine event in the same cycle wins over the clear.
- R5: Some bits always read as one: bank (0x06) bits 7:3, interrupt mask (0x09) bits 4:0 and address control (0x0A) bits 5:0. The remaining bits of each return what was last written.
- R6: There are three 16-bit registers: host address at 0x02 (low) and 0x03 (high), expansion address at 0x04 (low) and 0x05 (high), and length at 0x07 (low) and 0x08 (high). A byte write to any of them sets both the live value and the shadow to the new byte joined with the other byte of the shadow.
- R7: Writing the command register (0x01) with bits 7 and 4 both set produces exactly one start pulse, in the cycle after the write edge.
- R8: Writing the command register with bit 7 set and bit 4 clear arms the transfer. The next trig pulse then produces one start pulse in the following cycle. A trig pulse while not armed does nothing.
- R9: eng_done sets status bit 6 and clears command bit 7. It sets interrupt pending when mask bits 7 and 6 are both set.
- R10: eng_verr sets status bit 5. It sets interrupt pending when mask bits 7 and 5 are both set.
- R11: eng_wb loads the live host address, expansion address, bank and length from the engine inputs, and the shadows are left unchanged. eng_done with command bit 5 (auto-reload) set restores the live values from the shadows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the register window |
| addr | input | 5 | Register offset |
| we | input | 1 | Write enable (read when low) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| trig | input | 1 | External trigger strobe for an armed transfer |
| start | output | 1 | One-cycle transfer start pulse |
| irq | output | 1 | Interrupt request |
| xfer_mode | output | 2 | Command bits 1:0, transfer kind |
| autoload | output | 1 | Command bit 5, reload from shadows after a transfer |
| fix_host | output | 1 | Address control bit 7, host address held |
| fix_exp | output | 1 | Address control bit 6, expansion address held |
| cur_host | output | 16 | Live host address |
| cur_exp | output | 16 | Live expansion address |
| cur_bank | output | BANK_BITS | Live expansion bank |
| cur_len | output | 16 | Live transfer length |
| eng_done | input | 1 | Engine end-of-block event |
| eng_verr | input | 1 | Engine verify-mismatch event |
| eng_wb | input | 1 | Engine write-back of live values |
| eng_host | input | 16 | Host address from engine |
| eng_exp | input | 16 | Expansion address from engine |
| eng_bank | input | BANK_BITS | Bank from engine |
| eng_len | input | 16 | Length from engine |

## Verification
A corrupted shadow copy shows up at the ports only on the next single-byte write or the next auto-reload completion, so the bench forces both right after engine write-backs have made the live value and the shadow differ. A wrong status or mask bit appears on the next status read and on irq one cycle after the event. A wrong armed state appears as a missing or spurious start pulse one cycle after a trigger strobe.

// File: rtl/xdma_regs.sv
module xdma_regs #(
  parameter logic [3:0] VERSION   = 4'h0,
  parameter bit         BIG_MEM   = 1'b1,
  parameter int         BANK_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic [4:0]           addr,
  input  logic                 we,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  input  logic                 trig,
  output logic                 start,
  output logic                 irq,
  output logic [1:0]           xfer_mode,
  output logic                 autoload,
  output logic                 fix_host,
  output logic                 fix_exp,
  output logic [15:0]          cur_host,
  output logic [15:0]          cur_exp,
  output logic [BANK_BITS-1:0] cur_bank,
  output logic [15:0]          cur_len,
  input  logic                 eng_done,
  input  logic                 eng_verr,
  input  logic                 eng_wb,
  input  logic [15:0]          eng_host,
  input  logic [15:0]          eng_exp,
  input  logic [BANK_BITS-1:0] eng_bank,
  input  logic [15:0]          eng_len
);
  localparam int PAD = 8 - BANK_BITS;

  localparam logic [4:0] A_STAT  = 5'h00;
  localparam logic [4:0] A_CMD   = 5'h01;
  localparam logic [4:0] A_HLO   = 5'h02;
  localparam logic [4:0] A_HHI   = 5'h03;
  localparam logic [4:0] A_XLO   = 5'h04;
  localparam logic [4:0] A_XHI   = 5'h05;
  localparam logic [4:0] A_BANK  = 5'h06;
  localparam logic [4:0] A_LLO   = 5'h07;
  localparam logic [4:0] A_LHI   = 5'h08;
  localparam logic [4:0] A_MASK  = 5'h09;
  localparam logic [4:0] A_ACTL  = 5'h0A;

  logic                 st_verr, st_eob, st_irq;
  logic [7:0]           cmd;
  logic [15:0]          host, host_sh, expa, expa_sh, len, len_sh;
  logic [BANK_BITS-1:0] bank, bank_sh;
  logic [2:0]           imask;
  logic [1:0]           actl;
  logic                 armed;

  wire wr      = cs && we;
  wire rd_stat = cs && !we && (addr == A_STAT);
  wire cmd_wr  = wr && (addr == A_CMD);

  assign irq       = st_irq;
  assign xfer_mode = cmd[1:0];
  assign autoload  = cmd[5];
  assign fix_host  = actl[1];
  assign fix_exp   = actl[0];
  assign cur_host  = host;
  assign cur_exp   = expa;
  assign cur_bank  = bank;
  assign cur_len   = len;

  always_comb begin
    case (addr)
      A_STAT:  rdata = {st_irq, st_eob, st_verr, BIG_MEM, VERSION};
      A_CMD:   rdata = cmd;
      A_HLO:   rdata = host[7:0];
      A_HHI:   rdata = host[15:8];
      A_XLO:   rdata = expa[7:0];
      A_XHI:   rdata = expa[15:8];
      A_BANK:  rdata = {{PAD{1'b1}}, bank};
      A_LLO:   rdata = len[7:0];
      A_LHI:   rdata = len[15:8];
      A_MASK:  rdata = {imask, 5'h1F};
      A_ACTL:  rdata = {actl, 6'h3F};
      default: rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_verr <= 1'b0;
      st_eob  <= 1'b0;
      st_irq  <= 1'b0;
      cmd     <= 8'h10;
      host    <= '0;
      host_sh <= '0;
      expa    <= '0;
      expa_sh <= '0;
      bank    <= '0;
      bank_sh <= '0;
      len     <= 16'hFFFF;
      len_sh  <= 16'hFFFF;
      imask   <= '0;
      actl    <= '0;
      armed   <= 1'b0;
      start   <= 1'b0;
    end else begin
      start <= 1'b0;

      if (rd_stat) begin
        st_verr <= 1'b0;
        st_eob  <= 1'b0;
        st_irq  <= 1'b0;
      end

      if (eng_wb) begin
        host <= eng_host;
        expa <= eng_exp;
        bank <= eng_bank;
        len  <= eng_len;
      end

      if (eng_done) begin
        st_eob <= 1'b1;
        cmd[7] <= 1'b0;
        if (imask[2] && imask[1]) st_irq <= 1'b1;
        if (cmd[5]) begin
          host <= host_sh;
          expa <= expa_sh;
          bank <= bank_sh;
          len  <= len_sh;
        end
      end

      if (eng_verr) begin
        st_verr <= 1'b1;
        if (imask[2] && imask[0]) st_irq <= 1'b1;
      end

      if (armed && trig) begin
        start <= 1'b1;
        armed <= 1'b0;
      end

      if (cmd_wr) begin
        if (wdata[7] && wdata[4]) begin
          start <= 1'b1;
          armed <= 1'b0;
        end else begin
          armed <= wdata[7];
        end
      end

      if (wr) begin
        case (addr)
          A_CMD: cmd <= wdata;
          A_HLO: begin host <= {host_sh[15:8], wdata}; host_sh <= {host_sh[15:8], wdata}; end
          A_HHI: begin host <= {wdata, host_sh[7:0]};  host_sh <= {wdata, host_sh[7:0]};  end
          A_XLO: begin expa <= {expa_sh[15:8], wdata}; expa_sh <= {expa_sh[15:8], wdata}; end
          A_XHI: begin expa <= {wdata, expa_sh[7:0]};  expa_sh <= {wdata, expa_sh[7:0]};  end
          A_BANK: begin bank <= wdata[BANK_BITS-1:0]; bank_sh <= wdata[BANK_BITS-1:0]; end
          A_LLO: begin len <= {len_sh[15:8], wdata}; len_sh <= {len_sh[15:8], wdata}; end
          A_LHI: begin len <= {wdata, len_sh[7:0]};  len_sh <= {wdata, len_sh[7:0]};  end
          A_MASK: imask <= wdata[7:5];
          A_ACTL: actl  <= wdata[7:6];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xdma_regs_chk.sv
module xdma_regs_chk #(
  parameter int BANK_BITS = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       we,
  input logic [4:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       trig,
  input logic       start,
  input logic       irq,
  input logic       eng_done,
  input logic       eng_verr,
  input logic [2:0] imask
);
  localparam logic [7:0] BANK_ONES = ~((8'd1 << BANK_BITS) - 8'd1);

  assert_unused_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr >= 5'h0B) |-> (rdata == 8'hFF));

  assert_status_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 5'h00 && !eng_done && !eng_verr) |=> (irq == $past(irq)));

  assert_irq_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == 5'h00 && !eng_done && !eng_verr) |=> !irq);

  assert_bank_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 5'h06) |-> ((rdata & BANK_ONES) == BANK_ONES));

  assert_start_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($past(cs && we && addr == 5'h01 && wdata[7]) || $past(trig)));

  assert_done_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && imask[2] && imask[1]) |=> irq);

  assert_verr_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_verr && imask[2] && imask[0]) |=> irq);
endmodule

bind xdma_regs xdma_regs_chk #(.BANK_BITS(BANK_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .rdata(rdata), .trig(trig), .start(start), .irq(irq),
  .eng_done(eng_done), .eng_verr(eng_verr), .imask(imask)
);

// File: tb/xdma_regs_bench.sv
module xdma_regs_bench;
  localparam logic [3:0] VER = 4'h2;
  localparam logic [7:0] SBASE = {4'b0001, VER};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0, trig = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0;
  logic eng_done = 0, eng_verr = 0, eng_wb = 0;
  logic [15:0] eng_host = 0, eng_exp = 0, eng_len = 0;
  logic [2:0] eng_bank = 0;
  logic [7:0] rdata;
  logic start, irq, autoload, fix_host, fix_exp;
  logic [1:0] xfer_mode;
  logic [15:0] cur_host, cur_exp, cur_len;
  logic [2:0] cur_bank;

  int checks = 0, errors = 0;
  logic done_flag = 0;

  always #2 clk = ~clk;

  xdma_regs #(.VERSION(VER), .BIG_MEM(1'b1), .BANK_BITS(3)) u_xdma_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .trig(trig), .start(start), .irq(irq), .xfer_mode(xfer_mode),
    .autoload(autoload), .fix_host(fix_host), .fix_exp(fix_exp),
    .cur_host(cur_host), .cur_exp(cur_exp), .cur_bank(cur_bank), .cur_len(cur_len),
    .eng_done(eng_done), .eng_verr(eng_verr), .eng_wb(eng_wb),
    .eng_host(eng_host), .eng_exp(eng_exp), .eng_bank(eng_bank), .eng_len(eng_len)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a; #1 d = rdata;
    @(negedge clk); cs = 0;
  endtask

  task automatic rchk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic pulse_done();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic pulse_verr();
    @(negedge clk); eng_verr = 1;
    @(negedge clk); eng_verr = 0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] rv [0:10];
    logic [7:0] d;
    logic [15:0] hv;
    rv[0] = SBASE; rv[1] = 8'h10; rv[2] = 0; rv[3] = 0; rv[4] = 0; rv[5] = 0;
    rv[6] = 8'hF8; rv[7] = 8'hFF; rv[8] = 8'hFF; rv[9] = 8'h1F; rv[10] = 8'h3F;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    chk("R1 irq", {15'd0, irq}, 16'd0);
    for (int i = 0; i < 11; i++) rchk("R1 reset", i[4:0], rv[i]);

    // R2 unused offsets read ones, writes ignored
    for (int i = 11; i < 32; i++) begin
      wr(i[4:0], 8'h00);
      rchk("R2 unused read", i[4:0], 8'hFF);
    end
    for (int i = 1; i < 11; i++) rchk("R2 no side effect", i[4:0], rv[i]);

    // R3 status read-only
    wr(5'h00, 8'hFF);
    rchk("R3 status ro", 5'h00, SBASE);
    chk("R3 irq", {15'd0, irq}, 16'd0);

    // R5 forced ones, sweep
    for (int v = 0; v < 256; v += 37) begin
      wr(5'h06, v[7:0]); rchk("R5 bank", 5'h06, v[7:0] | 8'hF8);
      wr(5'h09, v[7:0]); rchk("R5 mask", 5'h09, v[7:0] | 8'h1F);
      wr(5'h0A, v[7:0]); rchk("R5 actl", 5'h0A, v[7:0] | 8'h3F);
      chk("R5 fix_host", {15'd0, fix_host}, {15'd0, v[7]});
      chk("R5 fix_exp", {15'd0, fix_exp}, {15'd0, v[6]});
    end

    // R6 16-bit merge
    for (int r = 0; r < 3; r++) begin
      logic [4:0] lo;
      lo = (r == 0) ? 5'h02 : (r == 1) ? 5'h04 : 5'h07;
      for (int v = 0; v < 4; v++) begin
        hv = 16'h1111 * (v + 1) + 16'h0F0F * r[15:0];
        wr(lo, hv[7:0]);
        wr(lo + 5'd1, hv[15:8]);
        rchk("R6 lo", lo, hv[7:0]);
        rchk("R6 hi", lo + 5'd1, hv[15:8]);
      end
    end

    // R11 write-back leaves shadow, next byte write merges shadow
    wr(5'h02, 8'h34); wr(5'h03, 8'h12);
    @(negedge clk); eng_wb = 1; eng_host = 16'hABCD; eng_exp = 16'h5678;
    eng_bank = 3'd2; eng_len = 16'h0042;
    @(negedge clk); eng_wb = 0;
    chk("R11 wb host", cur_host, 16'hABCD);
    rchk("R11 wb hi", 5'h03, 8'hAB);
    rchk("R11 wb bank", 5'h06, 8'hFA);
    wr(5'h02, 8'h55);
    rchk("R6 shadow reload hi", 5'h03, 8'h12);
    rchk("R6 shadow lo", 5'h02, 8'h55);

    // R7 immediate start
    wr(5'h09, 8'h00);
    @(negedge clk); cs = 1; we = 1; addr = 5'h01; wdata = 8'h90;
    @(negedge clk); cs = 0; we = 0;
    chk("R7 start pulse", {15'd0, start}, 16'd1);
    @(negedge clk);
    chk("R7 start single", {15'd0, start}, 16'd0);
    rchk("R7 cmd readback", 5'h01, 8'h90);

    // R9 completion, mask sweep
    for (int m = 0; m < 8; m++) begin
      wr(5'h09, {m[2:0], 5'h00});
      wr(5'h01, 8'h90);
      pulse_done();
      chk("R9 irq", {15'd0, irq}, {15'd0, m[2] & m[1]});
      rchk("R9 status", 5'h00, SBASE | 8'h40 | ((m[2] & m[1]) ? 8'h80 : 8'h00));
      chk("R4 irq cleared", {15'd0, irq}, 16'd0);
      rchk("R4 status cleared", 5'h00, SBASE);
      rchk("R9 cmd bit7 cleared", 5'h01, 8'h10);
    end

    // R10 verify error, mask sweep
    for (int m = 0; m < 8; m++) begin
      wr(5'h09, {m[2:0], 5'h00});
      pulse_verr();
      chk("R10 irq", {15'd0, irq}, {15'd0, m[2] & m[0]});
      rchk("R10 status", 5'h00, SBASE | 8'h20 | ((m[2] & m[0]) ? 8'h80 : 8'h00));
      rchk("R4 cleared", 5'h00, SBASE);
    end

    // R4 event wins over clear in same cycle
    wr(5'h09, 8'hE0);
    @(negedge clk); cs = 1; we = 0; addr = 5'h00; eng_verr = 1;
    #1 chk("R4 read value", {8'h00, rdata}, {8'h00, SBASE});
    @(negedge clk); cs = 0; eng_verr = 0;
    chk("R4 event wins", {15'd0, irq}, 16'd1);
    rchk("R4 after", 5'h00, SBASE | 8'hA0);

    // R8 deferred start
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    chk("R8 trig unarmed", {15'd0, start}, 16'd0);
    wr(5'h01, 8'h81);
    chk("R8 no immediate", {15'd0, start}, 16'd0);
    chk("R8 mode", {14'd0, xfer_mode}, 16'd1);
    repeat (3) @(negedge clk);
    chk("R8 waits", {15'd0, start}, 16'd0);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    chk("R8 start on trig", {15'd0, start}, 16'd1);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    chk("R8 disarmed", {15'd0, start}, 16'd0);

    // R11 autoload restore
    wr(5'h02, 8'h21); wr(5'h03, 8'h43);
    wr(5'h04, 8'h65); wr(5'h05, 8'h87);
    wr(5'h07, 8'h10); wr(5'h08, 8'h00);
    wr(5'h06, 8'h05);
    @(negedge clk); eng_wb = 1; eng_host = 16'h9999; eng_exp = 16'h8888;
    eng_bank = 3'd1; eng_len = 16'h0001;
    @(negedge clk); eng_wb = 0;
    chk("R11 wb len", cur_len, 16'h0001);
    wr(5'h01, 8'hB0);
    chk("R11 autoload out", {15'd0, autoload}, 16'd1);
    pulse_done();
    rchk("R11 host lo", 5'h02, 8'h21);
    rchk("R11 host hi", 5'h03, 8'h43);
    rchk("R11 exp hi", 5'h05, 8'h87);
    rchk("R11 bank", 5'h06, 8'hFD);
    rchk("R11 len lo", 5'h07, 8'h10);
    chk("R11 cur_exp", cur_exp, 16'h8765);
    chk("R11 cur_bank", {13'd0, cur_bank}, 16'd5);

    // no autoload: done keeps engine values
    @(negedge clk); eng_wb = 1; eng_host = 16'h7777;
    @(negedge clk); eng_wb = 0;
    wr(5'h01, 8'h90);
    pulse_done();
    chk("R11 no reload", cur_host, 16'h7777);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule